// File: doc/BRIEF.md
# Sticky Edge-Triggered Interrupt Controller

This block gathers twenty-six single-bit event lines from the subsystems of an audio converter into a bank of sticky status bits. The lines come from the clock generators, power sequencing, the output DAC, headphone detection, two serial audio ports and the one-bit stream decoder. A bit latches when its line goes from low to high, not while the line stays high. It stays latched until software reads the byte that holds it, and that read clears it. After a clearing read, a line that is still high does not set its bit again, so a second read shows whether anything new has happened.

A mask bit for each source decides whether its latched status can pull the shared active-low interrupt pin. Software reaches status and masks through a small register port with byte-wide data. Every read strobe on a status address clears the byte it returns. The event lines are taken as already synchronous to the block clock.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: A status bit is set by a 0-to-1 change of its event line between two consecutive clock edges. A line that stays high, including one held high through reset, sets nothing.
- R2: A set status bit stays set while its line falls and for any number of cycles, until a read of its status byte.
- R3: Status byte k (address k, k = 0..3) holds source bits 8k..8k+7 with bit 8k at data bit 0. A read shows the latched value combinationally while `rd_en` is high and clears only that byte at the clock edge. Other bytes keep their bits.
- R4: After a clearing read, a line that has stayed high does not set its bit again. Only a new rising change does.
- R5: After reset, all status bits read 0, all implemented mask bits read 1, and `irq_n` is 1. Bits 26..31 read 0 at every address.
- R6: `irq_n` is 0 exactly while at least one status bit is set whose mask bit is 0.
- R7: Mask byte k sits at address 4+k and is written with `wr_en`. A new mask value acts on `irq_n` after that clock edge and leaves the status bits unchanged. Reading a mask address clears nothing.
- R8: If a rising change of a line happens in the same cycle as a clearing read of its byte, the bit is set after the edge. The read still returns the value held before that edge.
- R9: Writes to status addresses 0..3 have no effect. Source index order: 0 PLL locked, 1 PLL fault, 2 crystal ready, 3 crystal fault, 4 power-down complete, 5 DAC overflow, 6 headphone inserted, 7 headphone removed, 8..12 port A (no frame clock, early, late, error, overload), 13..17 port B in the same order, 18 stream rate fault, 19 stream stuck, 20/21 stream invalid ch0/ch1, 22/23 stream silence ch0/ch1, 24 packed-stream marker seen, 25 packed-stream decoder active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_evt | input | 26 | Event lines, one per source, synchronous to clk |
| rd_en | input | 1 | Read strobe; clears the addressed status byte |
| wr_en | input | 1 | Write strobe for mask bytes |
| addr | input | 3 | Register address: 0..3 status, 4..7 mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high, 0 otherwise |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default of 26 sources and 8-bit registers. This gives four status bytes, and the top byte is only partly populated. That shape lets the bench check the unimplemented bits 26..31 at the status and mask addresses. It also lets it check that a read clears one byte while its neighbours keep their bits. A table of event patterns drives every source at once, including all-high, held-high and falling-only steps. Directed tests then cover the same-cycle edge and read, the effect of a mask change alone, and a line held high through reset.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int SRC_COUNT = 26;
    localparam int REG_W     = 8;

    function automatic int byte_count(input int nsrc, input int regw);
        return (nsrc + regw - 1) / regw;
    endfunction

    function automatic int addr_bits(input int nbytes);
        return (2 * nbytes <= 2) ? 1 : $clog2(2 * nbytes);
    endfunction

    typedef enum int {
        SRC_PLL_LOCK    = 0,
        SRC_PLL_FAULT   = 1,
        SRC_XO_READY    = 2,
        SRC_XO_FAULT    = 3,
        SRC_PD_DONE     = 4,
        SRC_DAC_OVF     = 5,
        SRC_HP_IN       = 6,
        SRC_HP_OUT      = 7,
        SRC_PA_NOFCLK   = 8,
        SRC_PA_EARLY    = 9,
        SRC_PA_LATE     = 10,
        SRC_PA_ERR      = 11,
        SRC_PA_OVLD     = 12,
        SRC_PB_NOFCLK   = 13,
        SRC_PB_EARLY    = 14,
        SRC_PB_LATE     = 15,
        SRC_PB_ERR      = 16,
        SRC_PB_OVLD     = 17,
        SRC_BS_RATE     = 18,
        SRC_BS_STUCK    = 19,
        SRC_BS_INV0     = 20,
        SRC_BS_INV1     = 21,
        SRC_BS_SIL0     = 22,
        SRC_BS_SIL1     = 23,
        SRC_PK_MARK     = 24,
        SRC_PK_ACTIVE   = 25
    } irq_src_e;
endpackage

// File: rtl/irq_access_decode.sv
module irq_access_decode #(
    parameter int NUM_BYTES = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BYTES-1:0] st_sel,
    output logic [NUM_BYTES-1:0] mk_sel,
    output logic [NUM_BYTES-1:0] clr_bytes,
    output logic [NUM_BYTES-1:0] wr_bytes
);
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_dec
        assign st_sel[k]    = (addr == ADDR_W'(k));
        assign mk_sel[k]    = (addr == ADDR_W'(NUM_BYTES + k));
        assign clr_bytes[k] = rd_en & st_sel[k];
        assign wr_bytes[k]  = wr_en & mk_sel[k];
    end
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int NUM_SRC   = 26,
    parameter int REG_W     = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SRC-1:0]   raw_evt,
    input  logic [NUM_BYTES-1:0] clr_bytes,
    output logic [NUM_SRC-1:0]   stat_q
);
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;

    // prev resets high so a line held high through reset is not an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= raw_evt;
    end

    assign rise = raw_evt & ~prev_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        localparam int BYTE_IDX = i / REG_W;
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[i] <= 1'b0;
            else
                // new edge wins over a clearing read in the same cycle
                stat_q[i] <= rise[i] | (stat_q[i] & ~clr_bytes[BYTE_IDX]);
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int NUM_SRC   = 26,
    parameter int REG_W     = 8,
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BYTES-1:0] wr_bytes,
    input  logic [REG_W-1:0]     wdata,
    output logic [NUM_SRC-1:0]   mask_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        localparam int BYTE_IDX = i / REG_W;
        localparam int BIT_IDX  = i % REG_W;
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[i] <= 1'b1;
            else if (wr_bytes[BYTE_IDX])
                mask_q[i] <= wdata[BIT_IDX];
        end
    end
endmodule

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC   = SRC_COUNT,
    parameter int DATA_W    = REG_W,
    parameter int NUM_BYTES = byte_count(NUM_SRC, DATA_W),
    parameter int ADDR_W    = addr_bits(NUM_BYTES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] raw_evt,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_n
);
    localparam int PAD_W = NUM_BYTES * DATA_W;

    logic [NUM_BYTES-1:0] st_sel, mk_sel, clr_bytes, wr_bytes;
    logic [NUM_SRC-1:0]   stat_q, mask_q;
    logic [PAD_W-1:0]     stat_pad, mask_pad;

    irq_access_decode #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_dec (
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .st_sel(st_sel), .mk_sel(mk_sel),
        .clr_bytes(clr_bytes), .wr_bytes(wr_bytes)
    );

    irq_edge_capture #(.NUM_SRC(NUM_SRC), .REG_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_cap (
        .clk(clk), .rst(rst), .raw_evt(raw_evt),
        .clr_bytes(clr_bytes), .stat_q(stat_q)
    );

    irq_mask_bank #(.NUM_SRC(NUM_SRC), .REG_W(DATA_W), .NUM_BYTES(NUM_BYTES)) u_msk (
        .clk(clk), .rst(rst), .wr_bytes(wr_bytes),
        .wdata(wdata), .mask_q(mask_q)
    );

    always_comb begin
        stat_pad = '0;
        mask_pad = '0;
        stat_pad[NUM_SRC-1:0] = stat_q;
        mask_pad[NUM_SRC-1:0] = mask_q;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int k = 0; k < NUM_BYTES; k++) begin
                if (st_sel[k]) rdata = stat_pad[k*DATA_W +: DATA_W];
                if (mk_sel[k]) rdata = mask_pad[k*DATA_W +: DATA_W];
            end
        end
    end

    assign irq_n = ~|(stat_q & ~mask_q);
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
    parameter int NUM_SRC   = 26,
    parameter int DATA_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int ADDR_W    = 3
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] raw_evt,
    input logic               rd_en,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [NUM_SRC-1:0] stat,
    input logic [NUM_SRC-1:0] mask,
    input logic               irq_n
);
    localparam int PAD_W = NUM_BYTES * DATA_W;

    logic [NUM_SRC-1:0] shadow_prev;
    logic [NUM_SRC-1:0] rise_sh;
    logic [NUM_SRC-1:0] clr_bits;
    logic [PAD_W-1:0]   mask_pad, valid_pad;

    always_ff @(posedge clk) begin
        if (rst) shadow_prev <= '1;
        else     shadow_prev <= raw_evt;
    end

    always_comb begin
        rise_sh = raw_evt & ~shadow_prev;
        for (int i = 0; i < NUM_SRC; i++)
            clr_bits[i] = rd_en && (addr == ADDR_W'(i / DATA_W));
        mask_pad  = '0;
        valid_pad = '0;
        mask_pad[NUM_SRC-1:0]  = mask;
        valid_pad[NUM_SRC-1:0] = '1;
    end

    // R8 / R1: every observed rising change is latched, even during a read
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(rise_sh) & ~stat) == '0));

    // R2: set bits not being read stay set
    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(stat & ~clr_bits)) == $past(stat & ~clr_bits)));

    // R4 / R1: a bit only appears after a rising change
    a_r4_no_level_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((stat & ~$past(stat)) & ~$past(rise_sh)) == '0));

    a_r6_irq_low: assert property (@(posedge clk) disable iff (rst)
        (|(stat & ~mask)) |-> !irq_n);

    a_r6_irq_high: assert property (@(posedge clk) disable iff (rst)
        !(|(stat & ~mask)) |-> irq_n);

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_mk
        // R7: mask byte takes the written value
        a_r7_mask_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(NUM_BYTES + k)) |=>
            (mask_pad[k*DATA_W +: DATA_W] == ($past(wdata) & valid_pad[k*DATA_W +: DATA_W])));
    end
endmodule

bind sticky_irq_ctrl irq_ctrl_checker #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .raw_evt(raw_evt), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .stat(stat_q), .mask(mask_q), .irq_n(irq_n)
);

// File: tb/tb_sticky_irq_ctrl.sv
module tb_sticky_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [25:0] raw_evt = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sticky_irq_ctrl dut (
        .clk(clk), .rst(rst), .raw_evt(raw_evt), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [25:0] raw;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{26'h0000000, 32'h00000000},
        '{26'h0000001, 32'h00000001},
        '{26'h3FFFFFF, 32'h03FFFFFE},
        '{26'h3FFFFFF, 32'h00000000},
        '{26'h1555555, 32'h00000000},
        '{26'h2AAAAAA, 32'h02AAAAAA},
        '{26'h2000000, 32'h00000000},
        '{26'h0F0F0F0, 32'h000F0F0F0 & 32'h03FFFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_status(output logic [31:0] s);
        logic [7:0] b0, b1, b2, b3;
        rd(3'd0, b0); rd(3'd1, b1); rd(3'd2, b2); rd(3'd3, b3);
        s = {b3, b2, b1, b0};
    endtask

    task automatic pulse(input int b);
        @(negedge clk); raw_evt[b] = 1'b1;
        @(negedge clk); raw_evt[b] = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] s;
        logic [7:0]  d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R5: reset state
        @(negedge clk);
        check("R5 irq_n", {31'd0, irq_n}, 32'd1);
        rd_status(s);
        check("R5 status", s, 32'h0);
        rd(3'd4, d); check("R5 mask0", {24'd0, d}, 32'hFF);
        rd(3'd7, d); check("R5 mask3 top bits", {24'd0, d}, 32'h03);

        // R1 R3 R4: vector table
        for (int v = 0; v < 8; v++) begin
            @(negedge clk); raw_evt = VEC[v].raw;
            @(posedge clk); #1;
            rd_status(s);
            check($sformatf("R1/R4 vec%0d", v), s, VEC[v].exp);
        end
        @(negedge clk); raw_evt = '0;
        rd_status(s);

        // R2: sticky after line falls
        pulse(3);
        repeat (5) @(negedge clk);
        rd(3'd0, d); check("R2 sticky", {24'd0, d}, 32'h08);
        rd(3'd0, d); check("R3 cleared", {24'd0, d}, 32'h00);

        // R4: held high, reread shows nothing new
        @(negedge clk); raw_evt[9] = 1'b1;
        @(negedge clk);
        rd(3'd1, d); check("R4 first read", {24'd0, d}, 32'h02);
        rd(3'd1, d); check("R4 held high", {24'd0, d}, 32'h00);
        @(negedge clk); raw_evt[9] = 1'b0;

        // R6: unmasked source drives irq_n
        wr(3'd4, 8'hF7);
        pulse(3);
        check("R6 irq asserted", {31'd0, irq_n}, 32'd0);
        rd(3'd0, d); check("R6 read", {24'd0, d}, 32'h08);
        @(negedge clk);
        check("R6 irq released", {31'd0, irq_n}, 32'd1);

        // R7: masked source, then unmask only
        pulse(10);
        check("R7 masked", {31'd0, irq_n}, 32'd1);
        wr(3'd5, 8'hFB);
        check("R7 unmask acts", {31'd0, irq_n}, 32'd0);
        rd(3'd5, d); check("R7 mask readback", {24'd0, d}, 32'hFB);
        check("R7 mask read no clear", {31'd0, irq_n}, 32'd0);
        rd(3'd1, d); check("R7 status intact", {24'd0, d}, 32'h04);
        @(negedge clk);
        check("R7 irq after clear", {31'd0, irq_n}, 32'd1);

        // R8: edge in the same cycle as clearing read
        pulse(1);
        @(negedge clk);
        rd_en = 1'b1; addr = 3'd0; raw_evt[0] = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1 rd_en = 1'b0;
        check("R8 read value", {24'd0, d}, 32'h02);
        rd(3'd0, d); check("R8 edge kept", {24'd0, d}, 32'h01);
        @(negedge clk); raw_evt[0] = 1'b0;

        // R3 per-byte clear, R9 status write ignored
        pulse(0); pulse(8); pulse(16);
        rd(3'd0, d); check("R3 byte0", {24'd0, d}, 32'h01);
        wr(3'd2, 8'h00);
        rd(3'd1, d); check("R3 byte1 kept", {24'd0, d}, 32'h01);
        rd(3'd2, d); check("R9 write ignored", {24'd0, d}, 32'h01);

        // R1: line high through reset
        @(negedge clk); raw_evt[5] = 1'b1; rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd0, d); check("R1 high through reset", {24'd0, d}, 32'h00);
        check("R5 irq after reset", {31'd0, irq_n}, 32'd1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule